// File: doc/BRIEF.md
# Memory Type Range Resolver

The resolver answers one question: which memory type applies to a physical address range? A configuration write port loads the type tables. These are one type byte for each small window of the lowest megabyte, a parameterised set of variable regions held as base/mask pairs, a default word, and a top-of-memory limit. A lookup request carries a start address and an exclusive end address. After the lookup, a one-cycle response pulse carries an 8-bit type code.

Lookups that resolve without the variable regions return their code in the cycle right after the request is taken. These are: an unloaded or globally disabled configuration, a hit in the low-megabyte table, and variable regions switched off. All other lookups walk the variable regions one per clock. A walk stops early on a partial-coverage error or a type conflict. When several regions cover the range, a fixed precedence merges their types: uncached wins, write-back with write-through gives write-through, and any other mismatch gives uncached.

Top module: `mtr_resolver`

## Requirements
- R1: Until the default word has been written once (config address 0x60), and whenever its enable field (bits 11:10) is zero, every lookup returns 0xFF.
- R2: With enable bit 10 set and start below 0x100000, the type is the low-table byte selected by start alone. Below 0x80000 the index is start>>16. From 0x80000 to 0xBFFFF it is 8+((start-0x80000)>>14). From 0xC0000 it is 24+((start-0xC0000)>>12). Low-table byte k is written at config address k (0 to 87). With bit 10 clear, the low table is bypassed.
- R3: When the lookup does not use the low table and enable bit 11 is clear, the default type (bits 7:0 of the default word) is returned.
- R4: A variable region takes part only when bit 11 of its mask word is set. Bits 11:0 of base and mask never take part in matching. The region type is bits 7:0 of its base word. Region i has its base at config address 0x80+2i and its mask at 0x81+2i.
- R5: The end address is made inclusive (end-1) before matching. A region matches an address when (addr & mask) equals (base & mask). If the region matches only one of start and inclusive end, the result is 0xFE.
- R6: If a second matching region is found and either the kept type or the new type is uncached (0), the result is uncached.
- R7: Write-back (6) merged with write-through (4), in either order, gives write-through.
- R8: Any other disagreement between matching types gives uncached (0).
- R9: If the limit (config address 0x61) is nonzero, start is at or above 2^32, and the inclusive end is below the limit, the result is write-back (6). This holds whatever the regions matched, provided no error or conflict ended the walk.
- R10: If no variable region matches, the default type is returned.
- R11: req_ready is high only when the block is idle. Early results appear 0 cycles after the accepting edge. A walk that stops at region k answers k+1 cycles after that edge. A full walk answers NVAR cycles after it. rsp_valid is one cycle wide and only rises while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CAW | Configuration register address |
| cfg_wdata | input | AW | Configuration write data |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block idle, request will be taken |
| req_start | input | AW | First byte address of the range |
| req_end | input | AW | Address one past the last byte |
| rsp_valid | output | 1 | Result pulse |
| rsp_type | output | 8 | Resolved type or error code |

## Verification
Every lookup has a response cycle fixed by its outcome. Early exits answer 0 cycles after the accepting edge. A walk that stops on region k answers k+1 cycles after that edge, and a complete walk answers NVAR cycles after it. The driver records the accepting edge's cycle number and computes both the expected code and the expected latency from the requirements. The monitor samples on falling edges and compares each code and each measured distance against the queued pair. A response that arrives with nothing queued counts as a mismatch.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  typedef logic [7:0] mtype_t;
  typedef enum logic {ST_IDLE, ST_SCAN} mtr_st_e;

  localparam mtype_t T_UC      = 8'h00;
  localparam mtype_t T_WT      = 8'h04;
  localparam mtype_t T_WB      = 8'h06;
  localparam mtype_t T_OFF     = 8'hFF;
  localparam mtype_t T_PARTIAL = 8'hFE;

  localparam int FIX_N  = 88;
  localparam int FIX_IW = 7;
  localparam int CA_DEF = 'h60;
  localparam int CA_TOM = 'h61;
  localparam int CA_VAR = 'h80;

  // {conflict, merged type}
  function automatic logic [8:0] mtr_merge(input mtype_t a, input mtype_t b);
    if (a == T_UC || b == T_UC) return {1'b1, T_UC};
    if ((a == T_WB && b == T_WT) || (a == T_WT && b == T_WB)) return {1'b0, T_WT};
    if (a != b) return {1'b1, T_UC};
    return {1'b0, a};
  endfunction
endpackage

// File: rtl/mtr_cfg_regs.sv
module mtr_cfg_regs
  import mtr_pkg::*;
#(
  parameter int NVAR = 8,
  parameter int AW   = 36,
  parameter int CAW  = 8,
  localparam int PW  = AW - 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [CAW-1:0]               wr_addr,
  input  logic [AW-1:0]                wr_data,
  output logic [FIX_N-1:0][7:0]        fix_tbl,
  output logic [7:0]                   dflt_type,
  output logic [1:0]                   dflt_en,
  output logic                         loaded,
  output logic [AW-1:0]                tom,
  output logic [NVAR-1:0][PW+7:0]      vbase,
  output logic [NVAR-1:0][PW:0]        vmask
);
  logic sel_def, sel_tom;
  assign sel_def = wr_en && (wr_addr == CAW'(CA_DEF));
  assign sel_tom = wr_en && (wr_addr == CAW'(CA_TOM));

  for (genvar g = 0; g < FIX_N; g++) begin : g_fix
    logic sel;
    assign sel = wr_en && (wr_addr == CAW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fix_tbl[g] <= '0;
      else if (sel) fix_tbl[g] <= wr_data[7:0];
    end
  end

  for (genvar v = 0; v < NVAR; v++) begin : g_var
    logic sel_b, sel_m;
    assign sel_b = wr_en && (wr_addr == CAW'(CA_VAR + 2*v));
    assign sel_m = wr_en && (wr_addr == CAW'(CA_VAR + 2*v + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vbase[v] <= '0;
        vmask[v] <= '0;
      end else begin
        if (sel_b) vbase[v] <= {wr_data[AW-1:12], wr_data[7:0]};
        if (sel_m) vmask[v] <= {wr_data[AW-1:12], wr_data[11]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dflt_type <= '0;
      dflt_en   <= '0;
      loaded    <= 1'b0;
    end else if (sel_def) begin
      dflt_type <= wr_data[7:0];
      dflt_en   <= wr_data[11:10];
      loaded    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tom <= '0;
    else if (sel_tom) tom <= wr_data;
  end

  // loaded only rises on a write to the default word
  assert_loaded_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> $past(wr_en && wr_addr == CAW'(CA_DEF)));
endmodule

// File: rtl/mtr_fix_index.sv
module mtr_fix_index
  import mtr_pkg::*;
(
  input  logic [7:0]        page_i,   // address bits 19:12
  output logic [FIX_IW-1:0] idx_o
);
  always_comb begin
    if (!page_i[7])      idx_o = FIX_IW'(page_i[6:4]);
    else if (!page_i[6]) idx_o = FIX_IW'(8)  + FIX_IW'(page_i[5:2]);
    else                 idx_o = FIX_IW'(24) + FIX_IW'(page_i[5:0]);
  end
endmodule

// File: rtl/mtr_range_cmp.sv
module mtr_range_cmp #(
  parameter int PW = 24
) (
  input  logic [PW-1:0] base_pg,
  input  logic [PW-1:0] mask_pg,
  input  logic [PW-1:0] lo_pg,
  input  logic [PW-1:0] hi_pg,
  output logic          lo_hit,
  output logic          hi_hit
);
  logic [PW-1:0] ref_pg;
  assign ref_pg = base_pg & mask_pg;
  assign lo_hit = (lo_pg & mask_pg) == ref_pg;
  assign hi_hit = (hi_pg & mask_pg) == ref_pg;
endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
  import mtr_pkg::*;
#(
  parameter int NVAR      = 8,
  parameter int AW        = 36,
  parameter int CAW       = 8,
  parameter bit HAS_FIXED = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_start,
  input  logic [AW-1:0]  req_end,
  output logic           rsp_valid,
  output logic [7:0]     rsp_type
);
  localparam int PW = AW - 12;
  localparam int IW = (NVAR > 1) ? $clog2(NVAR) : 1;
  localparam logic [IW-1:0] LAST = IW'(NVAR - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  logic [FIX_N-1:0][7:0]   fix_tbl;
  logic [7:0]              dflt_type;
  logic [1:0]              dflt_en;
  logic                    loaded;
  logic [AW-1:0]           tom;
  logic [NVAR-1:0][PW+7:0] vbase;
  logic [NVAR-1:0][PW:0]   vmask;

  mtr_cfg_regs #(.NVAR(NVAR), .AW(AW), .CAW(CAW)) u_cfg (
    .clk(clk), .rst_n(rst_ns), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .fix_tbl(fix_tbl), .dflt_type(dflt_type), .dflt_en(dflt_en), .loaded(loaded),
    .tom(tom), .vbase(vbase), .vmask(vmask)
  );

  logic [FIX_IW-1:0] fix_idx;
  logic              fix_low;
  mtr_fix_index u_fix (.page_i(req_start[19:12]), .idx_o(fix_idx));
  assign fix_low = (req_start[AW-1:20] == '0);

  // state
  mtr_st_e       st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] start_q, endi_q;
  logic          have_q, have_d;
  mtype_t        prev_q, prev_d;
  logic          rsp_v_q, rsp_v_d;
  mtype_t        rsp_t_q, rsp_t_d;
  logic          cap_en;

  // current region under test
  logic [PW+7:0] cur_b;
  logic [PW:0]   cur_m;
  logic          lo_hit, hi_hit, cur_valid;
  mtype_t        cur_type;
  logic [8:0]    merged;
  logic          tom_hit, fin;

  assign cur_b     = vbase[idx_q];
  assign cur_m     = vmask[idx_q];
  assign cur_type  = cur_b[7:0];
  assign cur_valid = cur_m[0];

  mtr_range_cmp #(.PW(PW)) u_cmp (
    .base_pg(cur_b[PW+7:8]), .mask_pg(cur_m[PW:1]),
    .lo_pg(start_q[AW-1:12]), .hi_pg(endi_q[AW-1:12]),
    .lo_hit(lo_hit), .hi_hit(hi_hit)
  );

  assign merged  = mtr_merge(prev_q, cur_type);
  assign tom_hit = (tom != '0) && (start_q[AW-1:32] != '0) && (endi_q < tom);
  assign cap_en  = req_valid && req_ready;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    have_d  = have_q;
    prev_d  = prev_q;
    rsp_v_d = 1'b0;
    rsp_t_d = rsp_t_q;
    fin     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          idx_d  = '0;
          have_d = 1'b0;
          prev_d = T_OFF;
          fin    = 1'b1;
          if (!loaded || dflt_en == 2'b00)            rsp_t_d = T_OFF;
          else if (HAS_FIXED && dflt_en[0] && fix_low) rsp_t_d = fix_tbl[fix_idx];
          else if (!dflt_en[1])                        rsp_t_d = dflt_type;
          else begin
            fin  = 1'b0;
            st_d = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (cur_valid && (lo_hit != hi_hit)) begin
          fin     = 1'b1;
          rsp_t_d = T_PARTIAL;
        end else if (cur_valid && lo_hit) begin
          if (!have_q) begin
            have_d = 1'b1;
            prev_d = cur_type;
          end else if (merged[8]) begin
            fin     = 1'b1;
            rsp_t_d = T_UC;
          end else begin
            prev_d = merged[7:0];
          end
        end
        if (!fin && idx_q == LAST) begin
          fin = 1'b1;
          if (tom_hit)     rsp_t_d = T_WB;
          else if (have_d) rsp_t_d = prev_d;
          else             rsp_t_d = dflt_type;
        end
        if (fin) st_d = ST_IDLE;
        else     idx_d = idx_q + IW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin) rsp_v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      have_q  <= 1'b0;
      prev_q  <= T_OFF;
      rsp_v_q <= 1'b0;
      rsp_t_q <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      have_q  <= have_d;
      prev_q  <= prev_d;
      rsp_v_q <= rsp_v_d;
      rsp_t_q <= rsp_t_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      start_q <= '0;
      endi_q  <= '0;
    end else if (cap_en) begin
      start_q <= req_start;
      endi_q  <= req_end - AW'(1);
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = rsp_v_q;
  assign rsp_type  = rsp_t_q;

  assert_unloaded_off_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (rsp_valid && !loaded) |-> (rsp_type == T_OFF));
  assert_accept_progress_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_ready) |=> (rsp_valid || !req_ready));
  assert_rsp_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid |-> req_ready);
  assert_fix_index_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_ready && fix_low) |-> (fix_idx < FIX_IW'(FIX_N)));
endmodule

// File: tb/tb_mtr_resolver.sv
module tb_mtr_resolver;
  import mtr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NVAR = 8;
  localparam int AW   = 36;
  localparam int CAW  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [CAW-1:0] cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic req_valid, req_ready, rsp_valid;
  logic [AW-1:0] req_start, req_end;
  logic [7:0] rsp_type;

  mtr_resolver #(.NVAR(NVAR), .AW(AW), .CAW(CAW), .HAS_FIXED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_start(req_start), .req_end(req_end),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-side configuration model
  logic [7:0]    m_fix [FIX_N];
  logic [11:0]   m_def;
  logic          m_loaded;
  logic [AW-1:0] m_tom;
  logic [AW-1:0] m_base [NVAR];
  logic [AW-1:0] m_mask [NVAR];

  // scoreboard
  logic [7:0] q_t[$];
  int         q_lat[$];
  int         q_acc[$];
  string      q_tag[$];
  int n_cmp = 0, n_bad = 0, n_push = 0, n_pop = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void ref_lookup(input logic [AW-1:0] s, input logic [AW-1:0] e_x,
                                     output logic [7:0] t, output int lat);
    logic [AW-1:0] e, mk, bs;
    logic sh, eh, have;
    logic [7:0] prev, cur;
    int idx;
    e = e_x - 1;
    lat = 0;
    if (!m_loaded || m_def[11:10] == 2'b00) begin t = 8'hFF; return; end
    if (m_def[10] && s < 36'h100000) begin
      if (s < 36'h80000)      idx = int'(s >> 16);
      else if (s < 36'hC0000) idx = 8 + int'((s - 36'h80000) >> 14);
      else                    idx = 24 + int'((s - 36'hC0000) >> 12);
      t = m_fix[idx];
      return;
    end
    if (!m_def[11]) begin t = m_def[7:0]; return; end
    have = 1'b0;
    prev = 8'hFF;
    for (int i = 0; i < NVAR; i++) begin
      lat = i + 1;
      if (!m_mask[i][11]) continue;
      mk = {m_mask[i][AW-1:12], 12'h000};
      bs = {m_base[i][AW-1:12], 12'h000};
      sh = ((s & mk) == (bs & mk));
      eh = ((e & mk) == (bs & mk));
      if (sh != eh) begin t = 8'hFE; return; end
      if (!sh) continue;
      cur = m_base[i][7:0];
      if (!have) begin have = 1'b1; prev = cur; continue; end
      if (prev == 8'h00 || cur == 8'h00) begin t = 8'h00; return; end
      if ((prev == 8'h06 && cur == 8'h04) || (prev == 8'h04 && cur == 8'h06)) begin
        prev = 8'h04; cur = 8'h04;
      end
      if (prev != cur) begin t = 8'h00; return; end
    end
    lat = NVAR;
    if (m_tom != '0 && s >= 36'h1_0000_0000 && e < m_tom) begin t = 8'h06; return; end
    t = have ? prev : m_def[7:0];
  endfunction

  task automatic cfg_write(input int a, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CAW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < FIX_N) m_fix[a] = d[7:0];
    else if (a == CA_DEF) begin m_def = d[11:0]; m_loaded = 1'b1; end
    else if (a == CA_TOM) m_tom = d;
    else if (a >= CA_VAR) begin
      if (a[0]) m_mask[(a - CA_VAR) / 2] = d;
      else      m_base[(a - CA_VAR) / 2] = d;
    end
  endtask

  task automatic set_var(input int i, input logic [AW-1:0] base, input logic [AW-1:0] size,
                         input logic [7:0] ty, input bit valid);
    // junk in bits 11:8 of base and 7:0 of mask must not matter (R4)
    cfg_write(CA_VAR + 2*i, base | 36'hA00 | AW'(ty));
    cfg_write(CA_VAR + 2*i + 1, (~(size - 1) & 36'hF_FFFF_F000) | (valid ? 36'h800 : 36'h0) | 36'h0FF);
  endtask

  task automatic lookup(input logic [AW-1:0] s, input logic [AW-1:0] e, input string tag);
    logic [7:0] t;
    int lat;
    @(negedge clk);
    ref_lookup(s, e, t, lat);
    q_t.push_back(t); q_lat.push_back(lat); q_acc.push_back(cyc + 1); q_tag.push_back(tag);
    n_push++;
    req_valid = 1'b1; req_start = s; req_end = e;
    @(negedge clk);
    req_valid = 1'b0;
    while (n_pop < n_push) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_t.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11 unexpected response actual=%0h expected=none", rsp_type);
      end else begin
        logic [7:0] t; int lat, acc; string tag;
        t = q_t.pop_front(); lat = q_lat.pop_front(); acc = q_acc.pop_front(); tag = q_tag.pop_front();
        chk(tag, 64'(rsp_type), 64'(t));
        chk({tag, " latency R11"}, 64'(cyc - acc), 64'(lat));
        n_pop++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < FIX_N; i++) m_fix[i] = '0;
    for (int i = 0; i < NVAR; i++) begin m_base[i] = '0; m_mask[i] = '0; end
    m_def = '0; m_loaded = 1'b0; m_tom = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_start = '0; req_end = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset rsp_valid", 64'(rsp_valid), 64'(0));
    chk("R11 reset req_ready", 64'(req_ready), 64'(1));

    lookup(36'h200000, 36'h201000, "R1 never loaded");
    cfg_write(CA_DEF, 36'h006);
    lookup(36'h200000, 36'h201000, "R1 enable field zero");

    for (int i = 0; i < FIX_N; i++) cfg_write(i, AW'(i));
    cfg_write(CA_DEF, 36'hC02);
    lookup(36'h00000, 36'h01000, "R2 first 64K entry");
    lookup(36'h7FFFF, 36'h80000, "R2 last 64K entry");
    lookup(36'h80000, 36'h81000, "R2 first 16K entry");
    lookup(36'hBFFFF, 36'hC0000, "R2 last 16K entry");
    lookup(36'hC0000, 36'hC1000, "R2 first 4K entry");
    lookup(36'hFF000, 36'h100000, "R2 last 4K entry");

    cfg_write(CA_DEF, 36'h402);
    lookup(36'h200000, 36'h201000, "R3 variable disabled");
    cfg_write(CA_DEF, 36'h802);
    lookup(36'h00000, 36'h01000, "R2 low table bypassed R10");

    cfg_write(CA_DEF, 36'hC02);
    set_var(0, 36'h100000, 36'h100000, T_WB, 1'b1);
    set_var(1, 36'h100000, 36'h080000, T_WT, 1'b1);
    set_var(2, 36'h400000, 36'h100000, T_UC, 1'b1);
    set_var(3, 36'h400000, 36'h200000, T_WB, 1'b1);
    set_var(4, 36'h800000, 36'h100000, 8'h01, 1'b1);
    set_var(5, 36'h800000, 36'h100000, T_WT, 1'b1);
    set_var(6, 36'h1000000, 36'h100000, 8'h05, 1'b0);

    lookup(36'h100000, 36'h101000, "R7 WB with WT");
    lookup(36'h180000, 36'h200000, "R5 inclusive end single WB");
    lookup(36'h180000, 36'h200001, "R5 end past region");
    lookup(36'h0FF000, 36'h101000, "R5 start before region");
    lookup(36'h400000, 36'h401000, "R6 uncached wins");
    lookup(36'h800000, 36'h801000, "R8 disagreement");
    lookup(36'h1000000, 36'h1001000, "R4 invalid region ignored R10");
    lookup(36'h3000000, 36'h3001000, "R10 no match");

    cfg_write(CA_TOM, 36'h2_0000_0000);
    lookup(36'h1_0000_0000, 36'h1_0000_1000, "R9 below limit");
    lookup(36'h1_FFFF_F000, 36'h2_0000_0000, "R9 end at limit");
    lookup(36'h2_0000_0000, 36'h2_0000_1000, "R9 above limit R10");
    lookup(36'h3000000, 36'h3001000, "R9 below 4G R10");

    repeat (5) @(negedge clk);
    if (q_t.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 missing responses actual=%0d expected=0", q_t.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule